// File: doc/BRIEF.md
# General Purpose Up-Counter Timer

An up-counting timer for interval generation and event timing. A prescaler divides a qualifying clock-enable input by a programmable ratio, and each resulting tick advances a counter while the timer is enabled. The counter either wraps at its all-ones value or restarts from zero on reaching the first compare value. Three compare channels raise status flags when the counter passes their programmed value. A rollover flag marks the wrap at all-ones. Each flag has an interrupt-enable bit, and the enabled flags combine into one registered interrupt line.

Software reaches the block through a plain synchronous register port. A write takes effect on the clock edge where the write enable is high. Read data is a combinational function of the address and the current state. There is no data stream, so no handshake is used. The counter width is a parameter (default 32 bits). Register data is 32 bits wide, and narrower fields read back zero-extended.

Register words: 0 control, 1 prescaler divide, 2 status, 3 interrupt enable, 4/5/6 compare values for channels 1/2/3, 7 counter (read only).

Top module: `gp_timer`

## Requirements
- R1: The counter changes only on a prescaled tick while control bit 0 is 1. Each tick adds one, except where R3 or R4 returns it to 0. With bit 0 clear, the counter and the prescaler phase hold.
- R2: The prescaler word (word 1, bits 11:0) holds N. While the timer is enabled, a tick occurs on every (N+1)-th cycle in which `clk_en` is high.
- R3: With control bit 9 = 1 (free-run), a tick while the counter is all-ones returns it to 0. Any tick at all-ones, in either mode, sets status bit 5 (rollover).
- R4: With control bit 9 = 0 (restart), a tick while the counter equals the channel-1 compare value returns it to 0.
- R5: A tick while the counter equals the compare value of channel k (k = 1, 2, 3) sets status bit k-1.
- R6: Writing status word 2 clears each of bits 0, 1, 2 and 5 that is written as 1. If a flag is set in the same cycle as its clear, the flag ends up set. All other status bits read 0.
- R7: `irq` is 1 in the cycle after any status bit is 1 while its interrupt-enable bit (word 3, same position among bits 0, 1, 2, 5) is 1. Otherwise `irq` is 0.
- R8: Writing control bit 15 as 1 starts a software reset. On the next edge, the counter, the prescaler phase and all status flags become 0, and bit 15 reads 0 again. Compare, prescaler, enable and other control bits keep their values.
- R9: Writing 1 to control bits 29, 30 or 31 sets status bit 0, 1 or 2 respectively on that edge. These bits always read 0.
- R10: After reset, every register reads 0. Writes to word 7 are ignored. Control bits 28:0 read back as written, and bit 15 reads back as described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Count qualifier fed to the prescaler |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable, sampled on the clock edge |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
A compare match or rollover can fall in the same cycle as a software write that clears that flag. The flag must survive that write. To provoke this, the bench uses restart mode with a divide of zero and a short period, and writes the clear mask on many consecutive cycles, so some writes land on match edges. A bench model that applies the set after the clear judges each readback of the status word. The same run also places force writes and software resets next to live matches.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;
  localparam int NUM_CMP = 3;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_PRE   = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] A_IEN   = 3'd3;
  localparam logic [REG_AW-1:0] A_CMP0  = 3'd4;
  localparam logic [REG_AW-1:0] A_COUNT = 3'd7;

  localparam int CB_EN    = 0;
  localparam int CB_FREE  = 9;
  localparam int CB_SRST  = 15;
  localparam int CB_FORCE = 29;
  localparam int CTRL_KEEP_W = CB_FORCE;

  localparam int SB_ROLL = 5;
  localparam logic [DATA_W-1:0] FLAG_MASK = 32'h0000_0027;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = run && !srst && (phase_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (srst)     phase_q <= '0;
    else if (tick)     phase_q <= '0;
    else if (run)      phase_q <= phase_q + 1'b1;
  end

  assert_tick_restarts_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q == '0));
  assert_idle_holds_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !srst) |=> $stable(phase_q));
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             tick,
  input  logic             free_mode,
  input  logic [CNT_W-1:0] restart_at,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic at_restart;

  assign wrap       = tick && (count == TOP);
  assign at_restart = tick && !free_mode && (count == restart_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (srst)               count <= '0;
    else if (wrap || at_restart) count <= '0;
    else if (tick)               count <= count + 1'b1;
  end

  assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !srst) |=> $stable(count));
  assert_free_increment_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && free_mode && count != TOP) |=> (count == $past(count) + 1'b1));
  assert_restart_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !free_mode && count == restart_at) |=> (count == '0));
  assert_srst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (count == '0));
endmodule

// File: rtl/gpt_compare.sv
module gpt_compare #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 3
) (
  input  logic                       tick,
  input  logic [CNT_W-1:0]           count,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp,
  output logic [N_CH-1:0]            hit
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign hit[i] = tick && (count == cmp[i]);
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [CTRL_KEEP_W-1:0]          ctrl_q;
  logic [PRE_W-1:0]                pre_q;
  logic [DATA_W-1:0]               stat_q, ien_q;
  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_q;
  logic [CNT_W-1:0]                count;
  logic                            tick, wrap, srst, run;
  logic [NUM_CMP-1:0]              hit, force_v;
  logic [DATA_W-1:0]               set_v, clr_v;
  logic                            wr_ctrl;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign srst    = ctrl_q[CB_SRST];
  assign run     = ctrl_q[CB_EN] && clk_en;

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .srst(srst), .run(run), .div(pre_q), .tick(tick));

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick),
    .free_mode(ctrl_q[CB_FREE]), .restart_at(cmp_q[0]), .count(count), .wrap(wrap));

  gpt_compare #(.CNT_W(CNT_W), .N_CH(NUM_CMP)) u_cmp (
    .tick(tick), .count(count), .cmp(cmp_q), .hit(hit));

  assign force_v = wr_ctrl ? reg_wdata[CB_FORCE +: NUM_CMP] : '0;

  always_comb begin
    set_v = '0;
    set_v[NUM_CMP-1:0] = hit | force_v;
    set_v[SB_ROLL]     = wrap;
    clr_v = (reg_we && reg_addr == A_STAT) ? (reg_wdata & FLAG_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl)       ctrl_q <= reg_wdata[CTRL_KEEP_W-1:0];
      else if (srst)     ctrl_q[CB_SRST] <= 1'b0;
      if (reg_we && reg_addr == A_PRE) pre_q <= reg_wdata[PRE_W-1:0];
      if (reg_we && reg_addr == A_IEN) ien_q <= reg_wdata & FLAG_MASK;
      for (int i = 0; i < NUM_CMP; i++) begin
        if (reg_we && reg_addr == A_CMP0 + REG_AW'(i)) cmp_q[i] <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= '0;
    else if (srst) stat_q <= '0;
    else           stat_q <= (stat_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat_q & ien_q);
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_KEEP_W-1:0] = ctrl_q;
      A_PRE:   reg_rdata[PRE_W-1:0] = pre_q;
      A_STAT:  reg_rdata = stat_q;
      A_IEN:   reg_rdata = ien_q;
      A_COUNT: reg_rdata[CNT_W-1:0] = count;
      default: begin
        for (int i = 0; i < NUM_CMP; i++) begin
          if (reg_addr == A_CMP0 + REG_AW'(i)) reg_rdata[CNT_W-1:0] = cmp_q[i];
        end
      end
    endcase
  end

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v && !srst) |=> ((stat_q & $past(set_v)) == $past(set_v)));
  assert_irq_follows_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ien_q)) |=> irq);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & ien_q)) |=> !irq);
  assert_srst_self_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !wr_ctrl) |=> !ctrl_q[CB_SRST]);
  assert_srst_clears_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (stat_q == '0));
  assert_force_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|force_v && !srst) |=> ((stat_q[NUM_CMP-1:0] & $past(force_v)) == $past(force_v)));
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, reg_we = 1'b0, irq;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_timer #(.CNT_W(CW), .PRE_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq(irq));

  logic [28:0] m_ctrl = '0;
  logic [11:0] m_pre = '0, m_pcnt = '0;
  logic [31:0] m_st = '0, m_ie = '0;
  logic [CW-1:0] m_cmp [3] = '{default: '0};
  logic [CW-1:0] m_cnt = '0;
  logic m_irq = 1'b0;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_ctrl};
      3'd1: return {20'b0, m_pre};
      3'd2: return m_st;
      3'd3: return m_ie;
      3'd4, 3'd5, 3'd6: return {{(32-CW){1'b0}}, m_cmp[a-3'd4]};
      default: return {{(32-CW){1'b0}}, m_cnt};
    endcase
  endfunction

  task automatic model_update(input logic we, input logic [2:0] a,
                              input logic [31:0] wd, input logic ce);
    logic srst, run, tick;
    logic [31:0] set, clr;
    logic [CW-1:0] ncnt;
    logic [11:0] npc;
    srst = m_ctrl[15];
    run  = !srst && m_ctrl[0] && ce;
    tick = run && (m_pcnt == m_pre);
    set = '0;
    if (tick) begin
      for (int i = 0; i < 3; i++) if (m_cnt == m_cmp[i]) set[i] = 1'b1;
      if (m_cnt == MAXV) set[5] = 1'b1;
    end
    if (we && a == 3'd0) set[2:0] = set[2:0] | wd[31:29];
    clr = (we && a == 3'd2) ? (wd & 32'h27) : '0;
    npc = srst ? '0 : (run ? (tick ? '0 : m_pcnt + 1'b1) : m_pcnt);
    if (srst) ncnt = '0;
    else if (tick) ncnt = ((!m_ctrl[9] && m_cnt == m_cmp[0]) || m_cnt == MAXV) ? '0 : m_cnt + 1'b1;
    else ncnt = m_cnt;
    m_irq  = |(m_st & m_ie);
    m_st   = srst ? '0 : ((m_st & ~clr) | set);
    m_cnt  = ncnt;
    m_pcnt = npc;
    if (we && a == 3'd0) m_ctrl = wd[28:0];
    else if (srst) m_ctrl[15] = 1'b0;
    if (we && a == 3'd1) m_pre = wd[11:0];
    if (we && a == 3'd3) m_ie = wd & 32'h27;
    if (we && a >= 3'd4 && a <= 3'd6) m_cmp[a-3'd4] = wd[CW-1:0];
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                      input logic ce, input string tag);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; clk_en = ce;
    #1;
    if (!we) begin
      checks++;
      if (reg_rdata !== model_read(a)) begin
        errors++;
        $display("FAIL %s word=%0d actual=%h expected=%h", tag, a, reg_rdata, model_read(a));
      end
    end
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL R7 (%s) irq actual=%b expected=%b", tag, irq, m_irq);
    end
    @(posedge clk);
    model_update(we, a, wd, ce);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b0, a, 32'h0, 1'b1, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b1, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) rd(3'(i), "R10 reset value");
    wr(3'd7, 32'h55, "R10");
    rd(3'd7, "R10 count write ignored");
    // disabled: counter holds
    for (int i = 0; i < 4; i++) rd(3'd7, "R1 hold while disabled");
    wr(3'd0, 32'h201, "R1");
    for (int i = 0; i < 6; i++) rd(3'd7, "R1 count per tick");
    wr(3'd1, 32'h2, "R2");
    for (int i = 0; i < 12; i++) rd(3'd7, "R2 prescaled count");
    for (int i = 0; i < 8; i++) step(1'b0, 3'd7, 0, i[0], "R2 gated clk_en");
    wr(3'd0, 32'hA000_0201, "R9");
    rd(3'd2, "R9 forced flags");
    rd(3'd0, "R9 force bits read zero");
    wr(3'd2, 32'hFFFF_FFFF, "R6");
    rd(3'd2, "R6 clear");
    wr(3'd4, 32'd7, "R4"); wr(3'd5, 32'd3, "R5"); wr(3'd6, 32'd5, "R5");
    wr(3'd0, 32'h0000_8201, "R8");
    rd(3'd7, "R8 count cleared");
    rd(3'd0, "R8 bit 15 self-cleared");
    rd(3'd4, "R8 compare kept");
    wr(3'd0, 32'h1, "R4"); wr(3'd1, 32'h0, "R4"); wr(3'd3, 32'h27, "R7");
    for (int i = 0; i < 24; i++) rd(3'(i[0] ? 2 : 7), "R4 R5 restart and matches");
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 2) rd(3'd2, "R6 set wins over clear");
      else wr(3'd2, 32'h27, "R6");
    end
    wr(3'd3, 32'h20, "R7");
    wr(3'd2, 32'h27, "R7");
    wr(3'd0, 32'h201, "R3");
    for (int i = 0; i < 4200; i++) rd(3'(i[0] ? 2 : 7), "R3 free-run wrap and rollover");
    for (int i = 0; i < 20000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom_range(0, 7));
      d = $urandom;
      case (a)
        3'd0: begin
          d[0] = ($urandom_range(0, 9) != 0);
          d[9] = ($urandom_range(0, 5) == 0);
          d[15] = ($urandom_range(0, 15) == 0);
        end
        3'd1: d = $urandom_range(0, 3);
        3'd4, 3'd5, 3'd6: d = $urandom_range(0, 40);
        default: ;
      endcase
      step($urandom_range(0, 9) < 3, a, d, $urandom_range(0, 3) != 0, "R5 R6 R10 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule